// File: doc/BRIEF.md
# Synchronous On-Die Termination Sequencer and Hold Monitor

This block turns the termination request of a DDR3-style memory device into a delayed termination-enable for the device's data pins. It applies to the synchronous termination mode only. The request is sampled on every rising clock edge while the clock-enable input is high. Each sample is passed through a delay line whose length is the configured additive latency plus the CAS write latency, minus two. The delay line produces two cycle-level markers. The first says the termination has left high impedance. The second says the termination is fully on. Together they stand in for the analog turn-on and turn-off windows.

The block also watches the request for early release. Once the request is sampled high it must stay high for a minimum number of sampled edges. A write command registered while the request is high opens a second window, whose length depends on the burst length of the write. A low sample is legal only when every open window has run out. A low sample that comes too early produces a one-cycle error pulse. The error pulse does not change the termination outputs, which still follow the delayed request.

Both latency settings are captured only while reset is held. Edges with the clock-enable low are not counted. On those edges the outputs, the delay line and the hold windows all stay as they are.

Top module: `term_sync_ctrl`

## Requirements
- R1: While reset is active, and after its release until a high request reaches the end of the delay line, `term_en`, `term_full` and `hold_err` are 0.
- R2: Let L = `al` + `cwl` − 2, with `al` and `cwl` captured during reset. Take a request sampled high on the k-th counted edge, where a counted edge is one with `cke` = 1. `term_en` goes to 1 on counted edge k+L.
- R3: Take a request sampled low on counted edge j after a high run. `term_full` goes to 0 on counted edge j+L and `term_en` goes to 0 on counted edge j+L+1.
- R4: `term_full` goes to 1 one counted edge after `term_en` goes to 1. It is never 1 while `term_en` is 0.
- R5: Take a low sample on counted edge i, following a run of high samples that began on counted edge a. If i − a < 4, `hold_err` is 1 for the cycle after edge i.
- R6: A write registered on counted edge m with the request sampled high opens a window. A low sample on counted edge i with i − m < 4 (`wr_bl8` = 0) or i − m < 6 (`wr_bl8` = 1) raises `hold_err` for one cycle.
- R7: The run-based window and all write windows apply together. A low sample is flagged whenever any one of them is still open, even after the run-based window has closed.
- R8: A write registered while the request is sampled low opens no window.
- R9: Edges with `cke` = 0 leave `term_en` and `term_full` unchanged, do not count toward any latency or window, and `hold_err` is 0 after them.
- R10: A flagged early release does not alter the termination outputs. They still follow the delayed request as in R2 and R3.
- R11: Changes of `al` or `cwl` while reset is inactive have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything acts on its rising edge |
| rst_n | input | 1 | Active-low reset; latency settings are captured while low |
| cke | input | 1 | Clock enable; an edge is counted only while high |
| odt | input | 1 | Termination request pin level |
| wr | input | 1 | Write command registered on this edge |
| wr_bl8 | input | 1 | Burst length of the write: 1 = eight, 0 = four |
| al | input | AL_W | Additive latency setting |
| cwl | input | CWL_W | CAS write latency setting |
| term_en | output | 1 | Termination out of high impedance (on or transitioning) |
| term_full | output | 1 | Termination fully on |
| hold_err | output | 1 | One-cycle pulse for a request released too early |

## Verification
The bench builds the block with its default parameters: a 22-stage delay line, hold windows of 4 and 6 edges, and 4-bit latency inputs. Three resets are used, giving latencies of 6, 3 and 22. These are the mid-range case, the shortest line the minimum write latency allows, and the full depth of the line. Together they exercise the tap selection at both ends. The short latency also reaches high runs whose release overlaps with turn-on. The 4-edge and 6-edge windows are close enough together that random runs and late writes land on both sides of each window boundary.

// File: rtl/term_pkg.sv
`timescale 1ns/1ps
package term_pkg;

   // latency in counted edges, clamped into the range the delay line holds
   function automatic int unsigned calc_lat(int unsigned al_v, int unsigned cwl_v,
                                            int unsigned max_v);
      int signed v;
      v = int'(al_v) + int'(cwl_v) - 2;
      if (v < 1) return 1;
      if (v > int'(max_v)) return max_v;
      return int'(v);
   endfunction

endpackage

// File: rtl/term_delay.sv
`timescale 1ns/1ps
module term_delay #(
   parameter int MAX_LAT = 22,
   parameter int LAT_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             din,
   input  logic [LAT_W-1:0] lat,
   output logic             q_out,
   output logic             r_out
);

   generate
      if (MAX_LAT < 2) begin : g_bad_depth
         $error("term_delay: MAX_LAT must be at least 2");
      end
      if ((1 << LAT_W) <= MAX_LAT) begin : g_bad_width
         $error("term_delay: LAT_W too small for MAX_LAT");
      end
   endgenerate

   logic [MAX_LAT-1:0] sreg;
   logic               tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sreg[0] <= 1'b0;
      else if (adv) sreg[0] <= din;
   end

   generate
      for (genvar gi = 1; gi < MAX_LAT; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sreg[gi] <= 1'b0;
            else if (adv) sreg[gi] <= sreg[gi-1];
         end
      end
   endgenerate

   always_comb begin
      tap = 1'b0;
      for (int i = 0; i < MAX_LAT; i++) begin
         if (lat == LAT_W'(i + 1)) tap = sreg[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_out <= 1'b0;
         r_out <= 1'b0;
      end else if (adv) begin
         q_out <= tap;
         r_out <= q_out;
      end
   end

   // R9: the outputs of the line move only on counted edges
   a_r9_line_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(q_out) && $stable(r_out));

endmodule

// File: rtl/term_hold.sv
`timescale 1ns/1ps
module term_hold #(
   parameter int HOLD_BL4 = 4,
   parameter int HOLD_BL8 = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic odt,
   input  logic wr,
   input  logic bl8,
   output logic err
);

   localparam int HMAX = (HOLD_BL8 > HOLD_BL4) ? HOLD_BL8 : HOLD_BL4;
   localparam int CW   = $clog2(HMAX + 1);

   generate
      if (HOLD_BL4 < 1 || HOLD_BL8 < 1) begin : g_bad_hold
         $error("term_hold: hold windows must be at least one edge");
      end
   endgenerate

   logic          prev;
   logic [CW-1:0] a_cnt;
   logic [CW-1:0] w_cnt;
   logic [CW-1:0] w_dec;
   logic [CW-1:0] w_load;
   logic [CW-1:0] w_next;
   logic          open;

   assign open   = (a_cnt != '0) || (w_cnt != '0);
   assign w_dec  = (w_cnt != '0) ? w_cnt - 1'b1 : '0;
   assign w_load = !wr ? '0 : (bl8 ? CW'(HOLD_BL8 - 1) : CW'(HOLD_BL4 - 1));
   assign w_next = (w_load > w_dec) ? w_load : w_dec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= 1'b0;
         a_cnt <= '0;
         w_cnt <= '0;
         err   <= 1'b0;
      end else begin
         err <= 1'b0;
         if (adv) begin
            prev <= odt;
            if (odt) begin
               if (!prev)            a_cnt <= CW'(HOLD_BL4 - 1);
               else if (a_cnt != '0) a_cnt <= a_cnt - 1'b1;
               w_cnt <= w_next;
            end else begin
               err   <= prev && open;
               a_cnt <= '0;
               w_cnt <= '0;
            end
         end
      end
   end

   // R5: an error pulse lasts exactly one cycle
   a_r5_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);

   // R5: an error follows only a counted edge that sampled the pin low
   a_r5_err_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(adv) && !$past(odt));

   // R8: a low sample leaves no window open, whatever the write strobe
   a_r8_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
      adv && !odt |=> (a_cnt == '0) && (w_cnt == '0));

   // R6: the write window never exceeds the longest hold
   a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      w_cnt <= CW'(HMAX - 1));

endmodule

// File: rtl/term_sync_ctrl.sv
`timescale 1ns/1ps
module term_sync_ctrl
   import term_pkg::*;
#(
   parameter int AL_W     = 4,
   parameter int CWL_W    = 4,
   parameter int AL_MAX   = 12,
   parameter int CWL_MIN  = 5,
   parameter int CWL_MAX  = 12,
   parameter int HOLD_BL4 = 4,
   parameter int HOLD_BL8 = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             odt,
   input  logic             wr,
   input  logic             wr_bl8,
   input  logic [AL_W-1:0]  al,
   input  logic [CWL_W-1:0] cwl,
   output logic             term_en,
   output logic             term_full,
   output logic             hold_err
);

   localparam int MAX_LAT = AL_MAX + CWL_MAX - 2;
   localparam int LAT_W   = $clog2(MAX_LAT + 1);

   generate
      if (CWL_MIN < 3) begin : g_bad_cwl
         $error("term_sync_ctrl: CWL_MIN must give a latency of at least one");
      end
      if (CWL_MAX < CWL_MIN) begin : g_bad_range
         $error("term_sync_ctrl: CWL_MAX below CWL_MIN");
      end
   endgenerate

   logic [LAT_W-1:0] lat_q;
   logic             q_s;
   logic             r_s;

   // settings are taken only while reset is held (R11)
   always_ff @(posedge clk) begin
      if (!rst_n) lat_q <= LAT_W'(calc_lat(int'(al), int'(cwl), MAX_LAT));
   end

   term_delay #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (cke),
      .din   (odt),
      .lat   (lat_q),
      .q_out (q_s),
      .r_out (r_s)
   );

   term_hold #(.HOLD_BL4(HOLD_BL4), .HOLD_BL8(HOLD_BL8)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (cke),
      .odt   (odt),
      .wr    (wr),
      .bl8   (wr_bl8),
      .err   (hold_err)
   );

   assign term_en   = q_s | r_s;
   assign term_full = q_s & r_s;

   // R11: the captured latency does not move outside reset
   a_r11_lat_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(lat_q));

   // R4: full termination is preceded by the leaving of high impedance
   a_r4_full_after_en: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(term_full) |-> $past(term_en));

   // R4: never fully on while in high impedance
   a_r4_full_within_en: assert property (@(posedge clk) disable iff (!rst_n)
      term_full |-> term_en);

   // R9: idle edges change no termination output
   a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> $stable(term_en) && $stable(term_full) && !hold_err);

endmodule

// File: tb/sim_term_sync_ctrl.sv
`timescale 1ns/1ps
module sim_term_sync_ctrl;

   localparam int MAXE = 4096;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b0, odt = 1'b0, wr = 1'b0, wr_bl8 = 1'b0;
   logic [3:0] al = 4'd3, cwl = 4'd5;
   logic       term_en, term_full, hold_err;

   int n_chk = 0, n_bad = 0;

   bit s [0:MAXE-1];
   int n_edge, lat_b, deadline;
   bit prev_b, exp_err;

   always #10 clk = ~clk;

   term_sync_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cke(cke), .odt(odt), .wr(wr), .wr_bl8(wr_bl8),
      .al(al), .cwl(cwl), .term_en(term_en), .term_full(term_full),
      .hold_err(hold_err)
   );

   function automatic bit s_at(int idx);
      if (idx < 1 || idx >= MAXE) return 1'b0;
      return s[idx];
   endfunction

   function automatic bit exp_en();
      return s_at(n_edge - lat_b) | s_at(n_edge - lat_b - 1);
   endfunction

   function automatic bit exp_full();
      return s_at(n_edge - lat_b) & s_at(n_edge - lat_b - 1);
   endfunction

   task automatic cmp(string tag, string what, bit act, bit exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0b expected=%0b edge=%0d", tag, what, act, exp, n_edge);
      end
   endtask

   task automatic check_all(string tag);
      cmp(tag, "term_en", term_en, exp_en());
      cmp(tag, "term_full", term_full, exp_full());
      cmp(tag, "hold_err", hold_err, exp_err);
   endtask

   // one cycle: check at negedge, drive, then update the model after the edge
   task automatic step(string tag, bit c, bit o, bit w, bit b8);
      @(negedge clk);
      check_all(tag);
      cke = c; odt = o; wr = w; wr_bl8 = b8;
      @(posedge clk);
      #1;
      exp_err = 1'b0;
      if (c) begin
         n_edge++;
         if (n_edge < MAXE) s[n_edge] = o;
         if (o) begin
            if (!prev_b) deadline = n_edge + 4;
            if (w) deadline = (n_edge + (b8 ? 6 : 4) > deadline) ? n_edge + (b8 ? 6 : 4) : deadline;
         end else begin
            exp_err = prev_b && (n_edge < deadline);
         end
         prev_b = o;
      end
   endtask

   task automatic do_reset(int a, int c);
      @(negedge clk);
      rst_n = 1'b0; cke = 1'b0; odt = 1'b0; wr = 1'b0; wr_bl8 = 1'b0;
      al = 4'(a); cwl = 4'(c);
      repeat (3) @(negedge clk);
      cmp("R1", "term_en", term_en, 1'b0);
      cmp("R1", "term_full", term_full, 1'b0);
      cmp("R1", "hold_err", hold_err, 1'b0);
      rst_n = 1'b1;
      for (int i = 0; i < MAXE; i++) s[i] = 1'b0;
      n_edge = 0; lat_b = a + c - 2; deadline = 0; prev_b = 1'b0; exp_err = 1'b0;
   endtask

   task automatic idle(string tag, int k);
      for (int i = 0; i < k; i++) step(tag, 1'b1, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic random_run(int cycles);
      int run = 0;
      bit lvl = 1'b0;
      for (int i = 0; i < cycles; i++) begin
         bit c, w, b;
         if (run == 0) begin
            lvl = ~lvl;
            run = lvl ? 1 + int'($urandom % 12) : 1 + int'($urandom % 10);
         end
         c = ($urandom % 10) != 0;
         w = ($urandom % 5) == 0;
         b = $urandom % 2;
         step(lvl ? "R2" : "R3", c, lvl, w, b);
         if (c) run--;
      end
   endtask

   initial begin
      void'($urandom(32'd5150));
      n_edge = 0; lat_b = 6; deadline = 0; prev_b = 0; exp_err = 0;

      // phase 1: latency 6
      do_reset(3, 5);
      idle("R1", 8);
      // R2/R3/R4: long clean pulse
      for (int i = 0; i < 10; i++) step("R2", 1, 1, 0, 0);
      idle("R3", 10);
      // R7: run window met, write at run edge 7 extends it; release at write+3
      for (int i = 0; i < 6; i++) step("R7", 1, 1, 0, 0);
      step("R7", 1, 1, 1, 0);
      for (int i = 0; i < 2; i++) step("R7", 1, 1, 0, 0);
      idle("R7", 3);
      // R7: same shape released at write+4 is legal
      for (int i = 0; i < 6; i++) step("R7", 1, 1, 0, 0);
      step("R7", 1, 1, 1, 0);
      for (int i = 0; i < 3; i++) step("R7", 1, 1, 0, 0);
      idle("R7", 3);
      // R6: burst-eight window, release at write+5 flagged, write+6 legal
      step("R6", 1, 1, 0, 0); step("R6", 1, 1, 1, 1);
      for (int i = 0; i < 4; i++) step("R6", 1, 1, 0, 0);
      idle("R6", 3);
      step("R6", 1, 1, 0, 0); step("R6", 1, 1, 1, 1);
      for (int i = 0; i < 5; i++) step("R6", 1, 1, 0, 0);
      idle("R6", 3);
      // R8: writes while low, then a legal 4-edge run
      for (int i = 0; i < 3; i++) step("R8", 1, 0, 1, 1);
      for (int i = 0; i < 4; i++) step("R8", 1, 1, 0, 0);
      idle("R8", 10);
      // R9: idle edges inside a run do not count toward the window
      step("R9", 1, 1, 0, 0); step("R9", 1, 1, 0, 0);
      for (int i = 0; i < 4; i++) step("R9", 0, 1, 0, 0);
      step("R9", 1, 1, 0, 0);
      step("R9", 1, 0, 0, 0);
      for (int i = 0; i < 3; i++) step("R9", 0, 0, 0, 0);
      idle("R9", 8);
      // R5/R10: two-edge pulse flagged, termination still follows it
      step("R5", 1, 1, 0, 0); step("R5", 1, 1, 0, 0);
      step("R5", 1, 0, 0, 0);
      idle("R10", 10);
      // R11: settings move outside reset, latency stays 6
      al = 4'd0; cwl = 4'd12;
      for (int i = 0; i < 5; i++) step("R11", 1, 1, 0, 0);
      idle("R11", 10);
      random_run(2500);

      // phase 2: shortest latency 3
      do_reset(0, 5);
      idle("R1", 4);
      random_run(2500);

      // phase 3: deepest latency 22
      do_reset(12, 12);
      idle("R1", 25);
      random_run(2500);
      idle("R3", 30);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 190000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule